// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block turns one prefixed instruction into a run of element operations. For each accepted instruction it issues elements on an output stream. Each element carries its element index and the operand register numbers, formed by adding the index to the base numbers taken from the suffix. The sums are wider than the suffix fields, so they can reach a larger register file. An instruction arrives on a valid/ready stream together with its prefix flag, a vector length, a mode bit and the base register fields. A single-cycle completion flag tells the front end that it may present the next instruction.

There are two loop orders. In horizontal-first mode every element of an instruction is issued in order, from index zero up to the vector length minus one, and only then is the next instruction taken. In vertical-first mode each prefixed instruction issues exactly one element, at a persistent offset that carries over from one instruction to the next. A separate step pulse moves that offset forward, and it wraps to zero at the end of the vector. An unprefixed instruction passes through as a single element at index zero.

The instruction stream accepts only while no element is pending, so the input side is stalled for the whole of a horizontal-first loop. The element stream follows the usual rules: an element stays valid with unchanged contents until the consumer takes it with ready high. Step and the two done flags are plain pulses.

Top module: `vec_elem_seq`

## Requirements
- R1: A prefixed instruction with mode bit `in_vf`=0 and vector length VL>0 issues VL elements with `el_idx` = 0, 1, ..., VL-1 in that order, with `el_vf`=0.
- R2: Each element's register number for operand i is the 5-bit base field `in_base[5i+4:5i]` plus `el_idx`, and it is presented on `el_reg[7i+6:7i]` as a 7-bit value, so sums above 31 up to 127 are exact.
- R3: `in_ready` is low from the cycle after acceptance until the last element is taken. `inst_done` is high in exactly the cycle in which the last element of an instruction is taken (`el_valid` and `el_ready` high).
- R4: A prefixed instruction with `in_vf`=1 and VL>0 issues exactly one element, at the current persistent offset, with `el_vf`=1. `inst_done` is high when that element is taken.
- R5: The persistent offset is the same for consecutive vertical-first instructions. Horizontal-first and unprefixed instructions leave it unchanged. Only a step changes it.
- R6: A `step` pulse adds one to the persistent offset. If offset+1 is at least the step bound (the VL of the most recently accepted vertical-first instruction, 0 after reset), the offset becomes 0 instead and `loop_done` is high for one cycle, in the cycle after the step.
- R7: An unprefixed instruction (`in_prefixed`=0) issues one element with `el_idx`=0 and `el_vf`=0, whatever its VL and mode bit, and does not change the step bound.
- R8: A prefixed instruction with VL=0 issues no element. `inst_done` is high in its acceptance cycle.
- R9: `el_err` is high with an element when any operand's base+index exceeds 127. The register outputs then carry the low 7 bits of the sum.
- R10: While `el_valid` is high and `el_ready` is low, the element (`el_valid`, `el_idx`, `el_reg`, `el_err`) holds unchanged on the next cycle.
- R11: Synchronous active-high reset leaves no element pending, `in_ready` high, `el_vf`=0 (horizontal-first), `loop_done` low and the persistent offset at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Sequencer can take an instruction |
| in_prefixed | input | 1 | Instruction carries a loop prefix |
| in_vf | input | 1 | 1 = vertical-first, 0 = horizontal-first |
| in_vl | input | 7 | Vector length |
| in_base | input | 15 | Three 5-bit base register fields, operand 0 in the low bits |
| el_valid | output | 1 | Element present |
| el_ready | input | 1 | Consumer takes the element |
| el_idx | output | 7 | Element index |
| el_reg | output | 21 | Three 7-bit offset register numbers, operand 0 in the low bits |
| el_err | output | 1 | Some operand register number is out of range |
| el_vf | output | 1 | Element comes from a vertical-first instruction |
| inst_done | output | 1 | Instruction finished, next one may be fetched |
| step | input | 1 | Advance the vertical-first offset |
| loop_done | output | 1 | Step wrapped the offset to zero |

## Verification
The first element is visible one cycle after acceptance. Later elements of a horizontal-first loop follow each taken element by one cycle. `inst_done` is combinational with the final element handshake, or with acceptance when the length is zero, and `loop_done` appears one cycle after the step pulse. The bench drives every input on the falling edge and samples one time unit later, in the same low phase. So it checks the combinational flags in the cycle of their handshake and the registered results in the first low phase after the capturing edge. A model of the persistent offset and step bound, kept inside the bench, predicts the start index for each vertical-first instruction and whether each step wraps.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic {
    MODE_HF = 1'b0,
    MODE_VF = 1'b1
  } vseq_mode_e;

endpackage

// File: rtl/vseq_counter.sv
module vseq_counter #(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [VL_W-1:0] load_off,
  input  logic [VL_W-1:0] load_end,
  input  logic            load_single,
  input  logic            adv,
  output logic [VL_W-1:0] off,
  output logic            last
);

  logic [VL_W-1:0] end_r;
  logic            single_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      off      <= '0;
      end_r    <= '0;
      single_r <= 1'b0;
    end else if (load) begin
      off      <= load_off;
      end_r    <= load_end;
      single_r <= load_single;
    end else if (adv) begin
      off <= off + 1'b1;
    end
  end

  assign last = single_r | (off == end_r);

endmodule

// File: rtl/vseq_vf_state.sv
module vseq_vf_state #(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            set_bound,
  input  logic [VL_W-1:0] bound_in,
  output logic [VL_W-1:0] vf_off,
  output logic            loop_done
);

  logic [VL_W-1:0] bound_r;
  logic [VL_W:0]   next_off;
  logic            wrap;

  assign next_off = {1'b0, vf_off} + 1'b1;
  assign wrap     = next_off >= {1'b0, bound_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      vf_off    <= '0;
      bound_r   <= '0;
      loop_done <= 1'b0;
    end else begin
      loop_done <= step & wrap;
      if (step) begin
        vf_off <= wrap ? '0 : next_off[VL_W-1:0];
      end
      if (set_bound) begin
        bound_r <= bound_in;
      end
    end
  end

endmodule

// File: rtl/vseq_reg_map.sv
module vseq_reg_map #(
  parameter int SFX_W = 5,
  parameter int REG_W = 7,
  parameter int NOPS  = 3,
  parameter int VL_W  = 7
) (
  input  logic [NOPS*SFX_W-1:0] base,
  input  logic [VL_W-1:0]       off,
  output logic [NOPS*REG_W-1:0] regs,
  output logic                  err
);

  localparam int SUM_W = ((REG_W > VL_W) ? REG_W : VL_W) + 1;

  logic [NOPS-1:0] err_vec;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    logic [SUM_W-1:0] sum;
    assign sum = {{(SUM_W-SFX_W){1'b0}}, base[i*SFX_W +: SFX_W]}
               + {{(SUM_W-VL_W){1'b0}}, off};
    assign regs[i*REG_W +: REG_W] = sum[REG_W-1:0];
    assign err_vec[i] = |sum[SUM_W-1:REG_W];
  end

  assign err = |err_vec;

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int SFX_W = 5,
  parameter int REG_W = 7,
  parameter int NOPS  = 3,
  parameter int VL_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_prefixed,
  input  logic                  in_vf,
  input  logic [VL_W-1:0]       in_vl,
  input  logic [NOPS*SFX_W-1:0] in_base,
  output logic                  el_valid,
  input  logic                  el_ready,
  output logic [VL_W-1:0]       el_idx,
  output logic [NOPS*REG_W-1:0] el_reg,
  output logic                  el_err,
  output logic                  el_vf,
  output logic                  inst_done,
  input  logic                  step,
  output logic                  loop_done
);

  logic                  busy;
  logic [NOPS*SFX_W-1:0] base_r;
  vseq_mode_e            mode_r;
  logic                  acc, zero_vl, start, vf_req, hs, last;
  logic [VL_W-1:0]       vf_off, off;

  assign acc     = in_valid & ~busy;
  assign zero_vl = in_prefixed & (in_vl == '0);
  assign start   = acc & ~zero_vl;
  assign vf_req  = in_prefixed & in_vf;
  assign hs      = busy & el_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      base_r <= '0;
      mode_r <= MODE_HF;
    end else if (start) begin
      busy   <= 1'b1;
      base_r <= in_base;
      mode_r <= vf_req ? MODE_VF : MODE_HF;
    end else if (hs && last) begin
      busy <= 1'b0;
    end
  end

  vseq_counter #(.VL_W(VL_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .load        (start),
    .load_off    (vf_req ? vf_off : '0),
    .load_end    (in_vl - 1'b1),
    .load_single (~in_prefixed | in_vf),
    .adv         (hs & ~last),
    .off         (off),
    .last        (last)
  );

  vseq_vf_state #(.VL_W(VL_W)) u_vf (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .set_bound (acc & vf_req),
    .bound_in  (in_vl),
    .vf_off    (vf_off),
    .loop_done (loop_done)
  );

  vseq_reg_map #(
    .SFX_W(SFX_W), .REG_W(REG_W), .NOPS(NOPS), .VL_W(VL_W)
  ) u_map (
    .base (base_r),
    .off  (off),
    .regs (el_reg),
    .err  (el_err)
  );

  assign in_ready  = ~busy;
  assign el_valid  = busy;
  assign el_idx    = off;
  assign el_vf     = (mode_r == MODE_VF);
  assign inst_done = (hs & last) | (acc & zero_vl);

endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
  parameter int REG_W = 7,
  parameter int NOPS  = 3,
  parameter int VL_W  = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_prefixed,
  input logic [VL_W-1:0]       in_vl,
  input logic                  el_valid,
  input logic                  el_ready,
  input logic [VL_W-1:0]       el_idx,
  input logic [NOPS*REG_W-1:0] el_reg,
  input logic                  el_err,
  input logic                  el_vf,
  input logic                  inst_done,
  input logic                  step,
  input logic                  loop_done
);

  // R3
  busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    el_valid |-> !in_ready);

  // R10
  elem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    el_valid && !el_ready |=> el_valid && $stable(el_idx) && $stable(el_reg) && $stable(el_err));

  // R1
  hf_next_idx_chk: assert property (@(posedge clk) disable iff (rst)
    el_valid && el_ready && !inst_done && !el_vf |=> el_valid && (el_idx == $past(el_idx) + 1'b1));

  // R4
  vf_single_chk: assert property (@(posedge clk) disable iff (rst)
    el_valid && el_ready && el_vf |-> inst_done);

  // R6
  loop_from_step_chk: assert property (@(posedge clk) disable iff (rst)
    loop_done |-> $past(step));

  // R8
  zero_len_done_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_prefixed && (in_vl == '0) |-> inst_done);

  // R8
  zero_len_idle_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_prefixed && (in_vl == '0) |=> !el_valid);

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !el_valid && !loop_done && !el_vf);

endmodule

bind vec_elem_seq vseq_checker #(.REG_W(REG_W), .NOPS(NOPS), .VL_W(VL_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_prefixed(in_prefixed), .in_vl(in_vl), .el_valid(el_valid),
  .el_ready(el_ready), .el_idx(el_idx), .el_reg(el_reg), .el_err(el_err),
  .el_vf(el_vf), .inst_done(inst_done), .step(step), .loop_done(loop_done)
);

// File: tb/vec_elem_seq_bench.sv
module vec_elem_seq_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_prefixed, in_vf, el_ready, step;
  logic [6:0]  in_vl;
  logic [14:0] in_base;
  logic        in_ready, el_valid, el_err, el_vf, inst_done, loop_done;
  logic [6:0]  el_idx;
  logic [20:0] el_reg;

  int checks = 0;
  int fails  = 0;
  int m_off  = 0;
  int m_bound = 0;

  always #5 clk = ~clk;

  vec_elem_seq u_vec_elem_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_prefixed(in_prefixed), .in_vf(in_vf), .in_vl(in_vl), .in_base(in_base),
    .el_valid(el_valid), .el_ready(el_ready), .el_idx(el_idx), .el_reg(el_reg),
    .el_err(el_err), .el_vf(el_vf), .inst_done(inst_done), .step(step),
    .loop_done(loop_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_instr(input string req, input bit pf, input bit vf, input int vl,
                           input int b0, input int b1, input int b2, input bit bp);
    int n, first, got, cyc;
    int b[3];
    b[0] = b0; b[1] = b1; b[2] = b2;
    if (!pf) begin n = 1; first = 0; end
    else if (vl == 0) begin n = 0; first = 0; end
    else if (vf) begin n = 1; first = m_off; end
    else begin n = vl; first = 0; end
    chk({req, " in_ready idle"}, int'(in_ready), 1);
    in_valid = 1'b1; in_prefixed = pf; in_vf = vf; in_vl = 7'(vl);
    in_base = {5'(b2), 5'(b1), 5'(b0)};
    #1;
    chk({req, " R8 done at accept"}, int'(inst_done), (pf && vl == 0) ? 1 : 0);
    if (pf && vf) m_bound = vl;
    @(negedge clk);
    in_valid = 1'b0;
    got = 0; cyc = 0;
    while (got < n && cyc < 1000) begin
      el_ready = bp ? cyc[0] : 1'b1;
      #1;
      chk({req, " R3 el_valid"}, int'(el_valid), 1);
      chk({req, " R3 in_ready busy"}, int'(in_ready), 0);
      if (el_valid) begin
        int idx;
        int e;
        idx = first + got;
        e = 0;
        chk({req, " R1 idx"}, int'(el_idx), idx);
        chk({req, " R4 el_vf"}, int'(el_vf), (pf && vf) ? 1 : 0);
        for (int i = 0; i < 3; i++) begin
          if (b[i] + idx > 127) e = 1;
          chk({req, " R2 reg"}, int'(el_reg[i*7 +: 7]), (b[i] + idx) % 128);
        end
        chk({req, " R9 err"}, int'(el_err), e);
        chk({req, " R3 inst_done"}, int'(inst_done), (el_ready && got == n - 1) ? 1 : 0);
        if (el_ready) got++;
      end
      @(negedge clk);
      cyc++;
    end
    el_ready = 1'b1;
    #1;
    chk({req, " R3 idle after"}, int'(el_valid), 0);
    chk({req, " R3 ready after"}, int'(in_ready), 1);
    @(negedge clk);
  endtask

  task automatic do_step(input string req);
    int wrap;
    wrap = (m_off + 1 >= m_bound) ? 1 : 0;
    m_off = wrap ? 0 : m_off + 1;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    #1;
    chk({req, " R6 loop_done"}, int'(loop_done), wrap);
    @(negedge clk);
    #1;
    chk({req, " R6 loop_done pulse end"}, int'(loop_done), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 el_valid", int'(el_valid), 0);
    chk("R11 in_ready", int'(in_ready), 1);
    chk("R11 el_vf", int'(el_vf), 0);
    chk("R11 loop_done", int'(loop_done), 0);
    chk("R11 inst_done", int'(inst_done), 0);
    @(negedge clk);
  endtask

  task automatic t_hf();
    run_instr("R1 hf vl4", 1, 0, 4, 3, 10, 20, 0);
    run_instr("R10 hf bp", 1, 0, 5, 1, 2, 30, 1);
    run_instr("R1 hf vl1", 1, 0, 1, 7, 8, 9, 0);
  endtask

  task automatic t_unpref();
    run_instr("R7 unprefixed", 0, 1, 9, 4, 5, 6, 0);
  endtask

  task automatic t_zero();
    run_instr("R8 zero vl", 1, 0, 0, 1, 1, 1, 0);
  endtask

  task automatic t_vf();
    run_instr("R11 R4 vf first at 0", 1, 1, 3, 1, 2, 3, 0);
    do_step("R6 step 0-1");
    run_instr("R5 vf at 1", 1, 1, 3, 1, 2, 3, 0);
    run_instr("R7 unpref between", 0, 0, 3, 1, 2, 3, 0);
    run_instr("R5 hf between", 1, 0, 2, 1, 2, 3, 1);
    run_instr("R5 vf still 1", 1, 1, 3, 4, 5, 6, 1);
    do_step("R6 step 1-2");
    run_instr("R4 vf at 2", 1, 1, 3, 4, 5, 6, 0);
    do_step("R6 step wrap");
    run_instr("R5 vf after wrap", 1, 1, 3, 4, 5, 6, 0);
  endtask

  task automatic t_range();
    run_instr("R9 R2 wide range", 1, 0, 127, 31, 0, 5, 0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_prefixed = 1'b0; in_vf = 1'b0;
    in_vl = '0; in_base = '0; el_ready = 1'b1; step = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hf();
    t_unpref();
    t_zero();
    t_vf();
    t_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule